// File: doc/BRIEF.md
# Two-Level Programmable Interrupt Priority Arbiter

This block takes a vector of already-masked interrupt requests and names the one request that should be serviced next. The sources are grouped: each of several first-level groups owns a fixed run of source indices. In each group, a subset of the sources follows an order that software sets, and two tail sources always rank below that subset. A second-level stage chooses among the group winners in an order that software also sets. After the groups, a small number of direct sources rank lowest of all.

The winning source is captured in an output register. The register holds both a one-hot pending vector and the encoded index, which a vector generator downstream can consume. While a source is being serviced, the capture is frozen. A service-clear pulse ends the service period, and arbitration then resumes. Two configuration words hold the group-level and top-level orderings. They are written through a simple write strobe with a select bit.

With the default parameters there are 26 sources: four groups of six, followed by two direct sources.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, svcPend is all zero, svcIdx is 0 and svcValid is 0. The group ordering word resets to 32'hE4E4E4E4 and the top ordering word resets to 8'hE4, so every code equals its own position index.
- R2: Group u owns source indices 6u to 6u+5. Indices 6u+0 to 6u+3 are the programmable sources at positions 0 to 3. Indices 6u+4 and 6u+5 are the tail sources. The direct sources are indices 24 and 25.
- R3: The 2-bit order code of group u, position j, sits at group-word bits [8u+2j+1 : 8u+2j], and code 0 ranks highest. Within a group, the active programmable source with the smallest code wins.
- R4: Both tail sources of a group rank below all four of its programmable sources, and 6u+4 ranks above 6u+5.
- R5: The 2-bit code of group u sits at top-word bits [2u+1 : 2u], and code 0 ranks highest. Among the groups with any active request, the one with the smallest code supplies the winner.
- R6: Direct source 24 wins only when no group has an active request. Source 25 wins only when no other source is active.
- R7: When two sources share a code, at either level, the one with the lower index ranks higher.
- R8: svcPend has at most one bit set. When svcValid is 1, that bit is svcPend[svcIdx].
- R9: While nothing is being serviced, the output register loads the winner of the requests seen at each clock edge, so the result appears one cycle later. With no request, it loads zero with svcValid 0.
- R10: While svcValid is 1 and svcClr is 0, svcPend, svcIdx and svcValid hold their values, whatever the requests or the configuration do.
- R11: svcClr while svcValid is 1 clears the outputs at the next edge, and arbitration resumes at the edge after that. svcClr while svcValid is 0 has no effect.
- R12: A write with cfgWrEn=1 and cfgWrSel=0 loads the group word from cfgWrData[31:0]. With cfgWrSel=1 it loads the top word from cfgWrData[7:0]. An arbitration at the same edge as the write still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqReq | input | 26 | Masked interrupt requests, one per source |
| svcClr | input | 1 | Pulse ending the current service period |
| cfgWrEn | input | 1 | Ordering-word write strobe |
| cfgWrSel | input | 1 | 0 selects the group word, 1 selects the top word |
| cfgWrData | input | 32 | Write data for the ordering words |
| svcPend | output | 26 | One-hot captured winner |
| svcIdx | output | 5 | Encoded index of the captured winner |
| svcValid | output | 1 | A winner is captured and under service |

## Verification
The bench builds the block with its default parameters: four groups of four programmable and two tail sources, plus two direct sources. That puts every level of the hierarchy within reach, including the 2-bit codes at both levels, both tail sources and both direct sources. Directed cases cover reversed orders, codes duplicated at each level and a configuration write landing on the same edge as a capture. A long random phase then mixes sparse requests, service clears and random ordering words, many of which contain duplicate codes.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  // Strobes from the service control to the datapath
  typedef struct packed {
    logic loadWin;   // capture the current winner (or nothing)
    logic clearOut;  // end of service: empty the output register
  } arbStrobe_t;

endpackage

// File: rtl/irq_arb_slave.sv
// First-level group: programmable-order sources followed by fixed tail sources.
module irq_arb_slave #(
  parameter int ProgCnt  = 4,
  parameter int FixedCnt = 2,
  localparam int UnitSrc = ProgCnt + FixedCnt,
  localparam int CodeW   = $clog2(ProgCnt),
  localparam int LocW    = $clog2(UnitSrc)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [UnitSrc-1:0]       req,
  input  logic [ProgCnt*CodeW-1:0] codes,
  output logic                     hit,
  output logic [LocW-1:0]          winLoc
);

  logic             progHit;
  logic [CodeW-1:0] bestCode;
  logic [LocW-1:0]  progLoc;
  logic [LocW-1:0]  tailLoc;

  // Smallest code wins; strict compare keeps the lower index on a tie (R3, R7)
  always_comb begin
    progHit  = 1'b0;
    bestCode = '0;
    progLoc  = '0;
    for (int j = 0; j < ProgCnt; j++) begin
      if (req[j] && (!progHit || codes[j*CodeW +: CodeW] < bestCode)) begin
        progHit  = 1'b1;
        bestCode = codes[j*CodeW +: CodeW];
        progLoc  = LocW'(j);
      end
    end
  end

  // Tail sources: lowest index first (R4)
  always_comb begin
    tailLoc = '0;
    for (int k = FixedCnt - 1; k >= 0; k--) begin
      if (req[ProgCnt + k]) tailLoc = LocW'(ProgCnt + k);
    end
  end

  assign hit    = |req;
  assign winLoc = progHit ? progLoc : tailLoc;

  // A tail source is chosen only when no programmable source is active
  assert_tail_below_prog_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hit && winLoc >= LocW'(ProgCnt)) |-> (req[ProgCnt-1:0] == '0));

  // The chosen local source is itself requesting
  assert_winner_requesting_R3: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> req[winLoc]);

endmodule

// File: rtl/irq_arb_master.sv
// Second-level stage: orders group winners, then the direct sources.
module irq_arb_master #(
  parameter int NumUnits  = 4,
  parameter int UnitSrc   = 6,
  parameter int NumDirect = 2,
  localparam int MCodeW   = $clog2(NumUnits),
  localparam int LocW     = $clog2(UnitSrc),
  localparam int NumSrc   = NumUnits * UnitSrc + NumDirect,
  localparam int IdxW     = $clog2(NumSrc)
) (
  input  logic [NumUnits-1:0]        unitHit,
  input  logic [NumUnits*LocW-1:0]   unitLoc,
  input  logic [NumDirect-1:0]       direct,
  input  logic [NumUnits*MCodeW-1:0] mCodes,
  output logic                       winValid,
  output logic [IdxW-1:0]            winIdx
);

  logic              unitFound;
  logic [MCodeW-1:0] bestCode;
  logic [IdxW-1:0]   unitIdx;
  logic [IdxW-1:0]   directIdx;

  // Smallest group code wins; tie keeps the lower group index (R5, R7)
  always_comb begin
    unitFound = 1'b0;
    bestCode  = '0;
    unitIdx   = '0;
    for (int u = 0; u < NumUnits; u++) begin
      if (unitHit[u] && (!unitFound || mCodes[u*MCodeW +: MCodeW] < bestCode)) begin
        unitFound = 1'b1;
        bestCode  = mCodes[u*MCodeW +: MCodeW];
        unitIdx   = IdxW'(u * UnitSrc) + IdxW'(unitLoc[u*LocW +: LocW]);
      end
    end
  end

  // Direct sources rank last, lower index first (R6)
  always_comb begin
    directIdx = '0;
    for (int d = NumDirect - 1; d >= 0; d--) begin
      if (direct[d]) directIdx = IdxW'(NumUnits * UnitSrc + d);
    end
  end

  assign winValid = unitFound | (|direct);
  assign winIdx   = unitFound ? unitIdx : directIdx;

endmodule

// File: rtl/irq_arb_ctrl.sv
// Service control: idle (capturing) or busy (holding until cleared).
module irq_arb_ctrl
  import irq_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       svcClr,
  input  logic       winAvail,
  output arbStrobe_t strb
);

  logic busyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
    end else if (!busyQ) begin
      busyQ <= winAvail;
    end else if (svcClr) begin
      busyQ <= 1'b0;
    end
  end

  always_comb begin
    strb.loadWin  = !busyQ;
    strb.clearOut = busyQ && svcClr;
  end

  // Clear during service ends the service at the next edge
  assert_clear_ends_service_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && svcClr) |=> !busyQ);

  // Idle without a winner stays idle
  assert_idle_without_request_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busyQ && !winAvail) |=> !busyQ);

endmodule

// File: rtl/irq_arb_datapath.sv
// Ordering words, group and top arbitration, captured result.
module irq_arb_datapath
  import irq_arb_pkg::*;
#(
  parameter int NumSlaves     = 4,
  parameter int ProgPerSlave  = 4,
  parameter int FixedPerSlave = 2,
  parameter int NumDirect     = 2,
  localparam int UnitSrc = ProgPerSlave + FixedPerSlave,
  localparam int NumSrc  = NumSlaves * UnitSrc + NumDirect,
  localparam int IdxW    = $clog2(NumSrc),
  localparam int CodeW   = $clog2(ProgPerSlave),
  localparam int MCodeW  = $clog2(NumSlaves),
  localparam int LocW    = $clog2(UnitSrc),
  localparam int SlvRegW = NumSlaves * ProgPerSlave * CodeW,
  localparam int MstRegW = NumSlaves * MCodeW
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NumSrc-1:0]  irqReq,
  input  arbStrobe_t         strb,
  input  logic               cfgWrEn,
  input  logic               cfgWrSel,
  input  logic [SlvRegW-1:0] cfgWrData,
  output logic               winAvail,
  output logic [NumSrc-1:0]  svcPend,
  output logic [IdxW-1:0]    svcIdx,
  output logic               svcValid
);

  function automatic logic [SlvRegW-1:0] slvIdentity();
    logic [SlvRegW-1:0] v;
    v = '0;
    for (int u = 0; u < NumSlaves; u++)
      for (int j = 0; j < ProgPerSlave; j++)
        v[(u*ProgPerSlave + j)*CodeW +: CodeW] = CodeW'(j);
    return v;
  endfunction

  function automatic logic [MstRegW-1:0] mstIdentity();
    logic [MstRegW-1:0] v;
    v = '0;
    for (int u = 0; u < NumSlaves; u++) v[u*MCodeW +: MCodeW] = MCodeW'(u);
    return v;
  endfunction

  localparam logic [SlvRegW-1:0] SlvReset = slvIdentity();
  localparam logic [MstRegW-1:0] MstReset = mstIdentity();

  logic [SlvRegW-1:0]        slvPrioQ;
  logic [MstRegW-1:0]        mstPrioQ;
  logic [NumSlaves-1:0]      unitHit;
  logic [NumSlaves*LocW-1:0] unitLoc;
  logic                      winValid;
  logic [IdxW-1:0]           winIdx;
  logic [NumSrc-1:0]         svcPendQ;
  logic [IdxW-1:0]           svcIdxQ;
  logic                      svcValidQ;

  // Ordering words (R12)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slvPrioQ <= SlvReset;
      mstPrioQ <= MstReset;
    end else if (cfgWrEn) begin
      if (!cfgWrSel) slvPrioQ <= cfgWrData;
      else           mstPrioQ <= cfgWrData[MstRegW-1:0];
    end
  end

  for (genvar u = 0; u < NumSlaves; u++) begin : g_slave
    irq_arb_slave #(
      .ProgCnt  (ProgPerSlave),
      .FixedCnt (FixedPerSlave)
    ) slave_i (
      .clk    (clk),
      .rstN   (rstN),
      .req    (irqReq[u*UnitSrc +: UnitSrc]),
      .codes  (slvPrioQ[u*ProgPerSlave*CodeW +: ProgPerSlave*CodeW]),
      .hit    (unitHit[u]),
      .winLoc (unitLoc[u*LocW +: LocW])
    );
  end

  irq_arb_master #(
    .NumUnits  (NumSlaves),
    .UnitSrc   (UnitSrc),
    .NumDirect (NumDirect)
  ) master_i (
    .unitHit  (unitHit),
    .unitLoc  (unitLoc),
    .direct   (irqReq[NumSrc-1 -: NumDirect]),
    .mCodes   (mstPrioQ),
    .winValid (winValid),
    .winIdx   (winIdx)
  );

  assign winAvail = winValid;

  // Captured result (R9, R10, R11)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      svcPendQ  <= '0;
      svcIdxQ   <= '0;
      svcValidQ <= 1'b0;
    end else if (strb.clearOut) begin
      svcPendQ  <= '0;
      svcIdxQ   <= '0;
      svcValidQ <= 1'b0;
    end else if (strb.loadWin) begin
      svcValidQ <= winValid;
      svcIdxQ   <= winValid ? winIdx : '0;
      svcPendQ  <= winValid ? (NumSrc'(1) << winIdx) : '0;
    end
  end

  assign svcPend  = svcPendQ;
  assign svcIdx   = svcIdxQ;
  assign svcValid = svcValidQ;

  assert_pend_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(svcPend));

  assert_index_matches_pend_R8: assert property (@(posedge clk) disable iff (!rstN)
    svcValid |-> svcPend[svcIdx]);

  assert_hold_in_service_R10: assert property (@(posedge clk) disable iff (!rstN)
    (svcValid && !strb.clearOut) |=> ($stable(svcPend) && $stable(svcIdx) && svcValid));

  assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearOut |=> (!svcValid && svcPend == '0));

  assert_first_direct_lowest_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(svcPend[NumSrc-NumDirect]) |-> ($past(irqReq[NumSrc-NumDirect-1:0]) == '0));

  assert_last_direct_lowest_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(svcPend[NumSrc-1]) |-> ($past(irqReq[NumSrc-2:0]) == '0));

endmodule

// File: rtl/irq_prio_arbiter.sv
// Thin top: service control plus arbitration datapath.
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NumSlaves     = 4,
  parameter int ProgPerSlave  = 4,
  parameter int FixedPerSlave = 2,
  parameter int NumDirect     = 2,
  localparam int NumSrc = NumSlaves * (ProgPerSlave + FixedPerSlave) + NumDirect,
  localparam int IdxW   = $clog2(NumSrc),
  localparam int CfgW   = NumSlaves * ProgPerSlave * $clog2(ProgPerSlave)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumSrc-1:0] irqReq,
  input  logic              svcClr,
  input  logic              cfgWrEn,
  input  logic              cfgWrSel,
  input  logic [CfgW-1:0]   cfgWrData,
  output logic [NumSrc-1:0] svcPend,
  output logic [IdxW-1:0]   svcIdx,
  output logic              svcValid
);

  arbStrobe_t strb;
  logic       winAvail;

  irq_arb_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .svcClr   (svcClr),
    .winAvail (winAvail),
    .strb     (strb)
  );

  irq_arb_datapath #(
    .NumSlaves     (NumSlaves),
    .ProgPerSlave  (ProgPerSlave),
    .FixedPerSlave (FixedPerSlave),
    .NumDirect     (NumDirect)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .irqReq    (irqReq),
    .strb      (strb),
    .cfgWrEn   (cfgWrEn),
    .cfgWrSel  (cfgWrSel),
    .cfgWrData (cfgWrData),
    .winAvail  (winAvail),
    .svcPend   (svcPend),
    .svcIdx    (svcIdx),
    .svcValid  (svcValid)
  );

endmodule

// File: tb/irq_prio_arbiter_tb.sv
module irq_prio_arbiter_tb_top;

  localparam int ClkPeriod = 10;
  localparam int NumSrc    = 26;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NumSrc-1:0] irqReq = '0;
  logic              svcClr = 1'b0;
  logic              cfgWrEn = 1'b0;
  logic              cfgWrSel = 1'b0;
  logic [31:0]       cfgWrData = '0;
  logic [NumSrc-1:0] svcPend;
  logic [4:0]        svcIdx;
  logic              svcValid;

  int checks = 0;
  int errors = 0;

  irq_prio_arbiter dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .irqReq    (irqReq),
    .svcClr    (svcClr),
    .cfgWrEn   (cfgWrEn),
    .cfgWrSel  (cfgWrSel),
    .cfgWrData (cfgWrData),
    .svcPend   (svcPend),
    .svcIdx    (svcIdx),
    .svcValid  (svcValid)
  );

  always #(ClkPeriod/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Flat ranking list built from the ordering words, first active entry wins
  function automatic int refWinner(logic [NumSrc-1:0] r, logic [31:0] s, logic [7:0] m);
    int order[$];
    for (int p = 0; p < 4; p++)
      for (int u = 0; u < 4; u++)
        if (int'(m[2*u +: 2]) == p) begin
          for (int q = 0; q < 4; q++)
            for (int j = 0; j < 4; j++)
              if (int'(s[8*u + 2*j +: 2]) == q) order.push_back(6*u + j);
          order.push_back(6*u + 4);
          order.push_back(6*u + 5);
        end
    order.push_back(24);
    order.push_back(25);
    foreach (order[i]) if (r[order[i]]) return order[i];
    return -1;
  endfunction

  // Cycle-by-cycle reference model
  logic              mBusy;
  logic [NumSrc-1:0] mPend;
  int                mIdx;
  logic              mValid;
  logic [31:0]       mSlv;
  logic [7:0]        mMst;
  int                w;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy = 0; mPend = '0; mIdx = 0; mValid = 0;
      mSlv = 32'hE4E4E4E4; mMst = 8'hE4;
    end else begin
      w = refWinner(irqReq, mSlv, mMst);
      if (!mBusy) begin
        mValid = (w >= 0);
        mBusy  = (w >= 0);
        mIdx   = (w >= 0) ? w : 0;
        mPend  = (w >= 0) ? (NumSrc'(1) << w) : '0;
      end else if (svcClr) begin
        mBusy = 0; mValid = 0; mPend = '0; mIdx = 0;
      end
      if (cfgWrEn) begin
        if (!cfgWrSel) mSlv = cfgWrData;
        else           mMst = cfgWrData[7:0];
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      check(svcPend == mPend && int'(svcIdx) == mIdx && svcValid == mValid,
            "model R9 R10 R11", {svcValid, svcIdx, svcPend}, {mValid, mIdx[4:0], mPend});
    end
  end

  function automatic logic [NumSrc-1:0] bits2(int a, int b);
    return (NumSrc'(1) << a) | (NumSrc'(1) << b);
  endfunction

  task automatic finishService();
    irqReq = '0;
    svcClr = 1'b1;
    @(negedge clk);
    check(!svcValid && svcPend == '0, "R11 clear", svcPend, 0);
    svcClr = 1'b0;
    @(negedge clk);
  endtask

  task automatic serve(input logic [NumSrc-1:0] req, input int exp, input string tag);
    irqReq = req;
    @(negedge clk);
    check(svcValid && int'(svcIdx) == exp && svcPend == (NumSrc'(1) << exp), tag, svcIdx, exp);
    finishService();
  endtask

  task automatic cfgWrite(input logic sel, input logic [31:0] data);
    cfgWrEn = 1'b1; cfgWrSel = sel; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  initial begin
    #(ClkPeriod * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(svcPend == '0 && svcIdx == '0 && !svcValid, "R1 reset state", svcPend, 0);
    @(negedge clk);
    check(!svcValid && svcPend == '0, "R9 no request loads zero", svcPend, 0);

    serve(bits2(2, 3), 2, "R3 identity order");
    serve(NumSrc'(1) << 9, 9, "R2 group1 position3");
    serve(bits2(4, 5), 4, "R4 tail pair order");
    serve(bits2(5, 1), 1, "R4 programmable over tail");
    serve(bits2(10, 11), 10, "R4 group1 tail");
    serve(bits2(7, 20), 7, "R5 identity top order");

    cfgWrite(1'b1, 32'h1B);
    serve(bits2(0, 19), 19, "R5 reversed top order");
    serve(bits2(0, 12), 12, "R5 group2 over group0");

    // R12: write on the same edge as a capture still uses the old order
    irqReq = bits2(0, 19);
    cfgWrEn = 1'b1; cfgWrSel = 1'b1; cfgWrData = 32'hE4;
    @(negedge clk);
    cfgWrEn = 1'b0;
    check(svcValid && svcIdx == 5'd19, "R12 old order at write edge", svcIdx, 19);
    finishService();
    serve(bits2(0, 19), 0, "R12 new order after write");

    serve(bits2(24, 25), 24, "R6 first direct over second");
    serve(bits2(25, 23), 23, "R6 group over direct");
    serve(NumSrc'(1) << 25, 25, "R6 last source alone");

    cfgWrite(1'b0, 32'hE4E4E41B);
    serve(bits2(0, 3), 3, "R3 reversed group order");
    serve(bits2(0, 1), 1, "R3 reversed pair");

    cfgWrite(1'b0, 32'hE4E4E400);
    serve(bits2(1, 2), 1, "R7 duplicate group codes");
    cfgWrite(1'b1, 32'h00);
    serve(bits2(13, 7), 7, "R7 duplicate top codes");
    cfgWrite(1'b0, 32'hE4E4E4E4);
    cfgWrite(1'b1, 32'hE4);

    // R10 hold while in service
    irqReq = NumSrc'(1) << 5;
    @(negedge clk);
    check($countones(svcPend) == 1 && svcPend[svcIdx], "R8 one-hot matches index", svcPend, 32);
    irqReq = NumSrc'(1);
    cfgWrEn = 1'b1; cfgWrSel = 1'b1; cfgWrData = 32'h1B;
    @(negedge clk);
    cfgWrEn = 1'b0;
    repeat (2) @(negedge clk);
    check(svcValid && svcIdx == 5'd5, "R10 hold during service", svcIdx, 5);
    finishService();
    cfgWrite(1'b1, 32'hE4);

    // R11 clear while idle is ignored
    irqReq = NumSrc'(1) << 3;
    svcClr = 1'b1;
    @(negedge clk);
    check(svcValid && svcIdx == 5'd3, "R11 idle clear ignored", svcIdx, 3);
    irqReq = '0;
    @(negedge clk);
    check(!svcValid, "R11 clear in service", svcValid, 0);
    svcClr = 1'b0;
    @(negedge clk);

    // Random phase against the model
    for (int i = 0; i < 4000; i++) begin
      irqReq    = NumSrc'($urandom) & NumSrc'($urandom) & NumSrc'($urandom);
      svcClr    = ($urandom % 4) == 0;
      cfgWrEn   = ($urandom % 12) == 0;
      cfgWrSel  = $urandom % 2;
      cfgWrData = $urandom;
      @(negedge clk);
    end
    irqReq = '0; svcClr = 1'b0; cfgWrEn = 1'b0;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule